// File: doc/BRIEF.md
# Exact-Match Receive Address Filter

This block holds a small table of station addresses and decides, for every received frame, whether its 48-bit destination address equals one of them. Software loads each entry through a word-wide register port as two 32-bit accesses: a low word and then a high word. The high word also carries the entry's address-valid flag. The frame side presents the destination address together with a strobe. One clock later the block returns a qualifier, a hit flag and the index of the matching entry.

Entry 0 holds the primary station address. Entry 0 refuses a replacement whose first byte marks a group (multicast) address. All entries are compared in parallel. When more than one entry matches, the lowest index wins. A low-word write does not change the entry directly. The word waits in a single staging register, and the entry it targets is kept out of the comparison until the matching high word commits the full address.

Top module: `rxaf_filter`

## Requirements
- R1: After reset every entry is invalid with zero contents, and `hit_vld`, `hit` and `hit_idx` are all zero.
- R2: The low register word maps address bytes in ascending significance. Byte 0 (the first byte on the wire, `lkup_addr[47:40]`) is bits 7:0, byte 1 is bits 15:8, byte 2 is bits 23:16 and byte 3 is bits 31:24.
- R3: The high register word carries byte 4 (`lkup_addr[15:8]`) in bits 7:0 and byte 5 (`lkup_addr[7:0]`) in bits 15:8. The address-valid flag is bit 31. Bits 30:16 have no effect.
- R4: An entry takes part in matching only while its valid flag is set. A high-word write with bit 31 clear makes the entry invalid.
- R5: An entry whose stored 48-bit address is all zero never matches, even with the valid flag set.
- R6: A low-word write stores the word in the staging register and suppresses matching on its target entry until a high-word write to that entry. The high-word write commits the staged word only if the most recent low write since the last high write targeted that same entry. Otherwise the entry keeps its previous low word.
- R7: A high-word write to entry 0 with bit 31 set is discarded whole when bit 0 of the committed byte 0 is 1. Entry 0 then keeps its previous address and validity, but its suppression is lifted.
- R8: `hit_vld` is high exactly one cycle after `lkup_vld`. `hit` is high only with `hit_vld`, and `hit_idx` is zero whenever `hit` is low.
- R9: When several usable entries match, `hit_idx` reports the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_hi | input | 1 | Selects the word: 0 = low word, 1 = high word |
| cfg_idx | input | 4 | Entry index of the write |
| cfg_wdata | input | 32 | Register write data |
| lkup_vld | input | 1 | Destination address strobe |
| lkup_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| hit_vld | output | 1 | Result qualifier, one cycle after the strobe |
| hit | output | 1 | An entry matched |
| hit_idx | output | 4 | Lowest matching entry index, zero on a miss |

## Verification
Directed patterns come first.
- A correctly ordered address and its byte-swapped twin tell the intended byte mapping apart from a reversed one.
- Duplicate addresses in several entries expose the priority order.
- A lone low write, a stale staged word and a group-bit replacement of entry 0 each separate the commit rules from a naive per-word update.
- An all-zero address stored with its flag set distinguishes the zero guard from a plain valid check.

A long seeded random run then mixes paired, lone-low and lone-high writes with lookups. Lookups are drawn mostly from addresses already in the table, so hits, misses and suppressed entries all occur often.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   localparam int unsigned MAC_W = 48;
   localparam int unsigned REG_W = 32;

   typedef enum logic {WORD_LO = 1'b0, WORD_HI = 1'b1} word_sel_e;

   // register layout -> wire order (first byte in the top bits)
   function automatic logic [MAC_W-1:0] wire_order(input logic [REG_W-1:0] lo,
                                                   input logic [15:0] hi);
      return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
   endfunction
endpackage

// File: rtl/rxaf_entry.sv
module rxaf_entry
   import rxaf_pkg::*;
#(
   parameter bit PRIMARY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_we,
   input  logic             hi_we,
   input  logic             stg_own,
   input  logic [REG_W-1:0] stg_word,
   input  logic [15:0]      hi_bytes,
   input  logic             av_in,
   input  logic [MAC_W-1:0] lkup_addr,
   output logic             match
);
   logic [REG_W-1:0] lo_q;
   logic [15:0]      hi_q;
   logic             av_q, pend_q;
   logic [REG_W-1:0] commit_lo;
   logic             reject;

   assign commit_lo = stg_own ? stg_word : lo_q;

   generate
      if (PRIMARY) begin : g_primary
         assign reject = av_in && commit_lo[0];
      end else begin : g_plain
         assign reject = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         av_q   <= 1'b0;
         pend_q <= 1'b0;
      end else if (lo_we) begin
         pend_q <= 1'b1;
      end else if (hi_we) begin
         pend_q <= 1'b0;
         if (!reject) begin
            lo_q <= commit_lo;
            hi_q <= hi_bytes;
            av_q <= av_in;
         end
      end
   end

   assign match = av_q && !pend_q && ({lo_q, hi_q} != '0) &&
                  (wire_order(lo_q, hi_q) == lkup_addr);
endmodule

// File: rtl/rxaf_prio.sv
module rxaf_prio #(
   parameter int unsigned N = 16,
   parameter int unsigned W = 4
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
   import rxaf_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 16,
   parameter int unsigned AV_BIT      = 31,
   localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_hi,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             lkup_vld,
   input  logic [MAC_W-1:0] lkup_addr,
   output logic             hit_vld,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);
   generate
      if (NUM_ENTRIES < 2) begin : g_bad_depth
         $error("rxaf_filter: NUM_ENTRIES must be at least 2");
      end
      if (AV_BIT < 16 || AV_BIT >= REG_W) begin : g_bad_av
         $error("rxaf_filter: AV_BIT must lie in the upper half of the high word");
      end
   endgenerate

   localparam logic [15:0] AV_MASK = 16'(1 << (AV_BIT - 16));

   logic             lo_wr, hi_wr;
   logic [REG_W-1:0] stg_q;
   logic [IDX_W-1:0] stg_idx_q;
   logic             stg_v_q;
   logic [NUM_ENTRIES-1:0] match_vec;
   logic             any_m;
   logic [IDX_W-1:0] first_m;
   logic             unused_hi;

   assign lo_wr     = cfg_we && (word_sel_e'(cfg_hi) == WORD_LO);
   assign hi_wr     = cfg_we && (word_sel_e'(cfg_hi) == WORD_HI);
   assign unused_hi = ^(cfg_wdata[31:16] & ~AV_MASK);

   // single staging register for the pending low word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q     <= '0;
         stg_idx_q <= '0;
         stg_v_q   <= 1'b0;
      end else if (lo_wr) begin
         stg_q     <= cfg_wdata;
         stg_idx_q <= cfg_idx;
         stg_v_q   <= 1'b1;
      end else if (hi_wr) begin
         stg_v_q   <= 1'b0;
      end
   end

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      logic sel;
      assign sel = (cfg_idx == IDX_W'(g));
      rxaf_entry #(.PRIMARY(g == 0)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .lo_we     (lo_wr && sel),
         .hi_we     (hi_wr && sel),
         .stg_own   (stg_v_q && (stg_idx_q == IDX_W'(g))),
         .stg_word  (stg_q),
         .hi_bytes  (cfg_wdata[15:0]),
         .av_in     (cfg_wdata[AV_BIT]),
         .lkup_addr (lkup_addr),
         .match     (match_vec[g])
      );
   end

   rxaf_prio #(.N(NUM_ENTRIES), .W(IDX_W)) u_prio (
      .req (match_vec),
      .any (any_m),
      .idx (first_m)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_vld <= 1'b0;
         hit     <= 1'b0;
         hit_idx <= '0;
      end else begin
         hit_vld <= lkup_vld;
         hit     <= lkup_vld && any_m;
         hit_idx <= (lkup_vld && any_m) ? first_m : '0;
      end
   end
endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk #(
   parameter int unsigned IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic             cfg_hi,
   input logic [IDX_W-1:0] cfg_idx,
   input logic             lkup_vld,
   input logic             hit_vld,
   input logic             hit,
   input logic [IDX_W-1:0] hit_idx
);
   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!hit_vld && !hit && hit_idx == '0);
      end
   end

   // R8
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lkup_vld |=> hit_vld);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lkup_vld |=> !hit_vld);

   // R8
   hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> hit_vld);

   // R8
   miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> hit_idx == '0);

   // R6
   pend_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_hi) ##1 lkup_vld |=> !(hit && hit_idx == $past(cfg_idx, 2)));
endmodule

bind rxaf_filter rxaf_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_hi   (cfg_hi),
   .cfg_idx  (cfg_idx),
   .lkup_vld (lkup_vld),
   .hit_vld  (hit_vld),
   .hit      (hit),
   .hit_idx  (hit_idx)
);

// File: tb/tb_rxaf_filter.sv
`timescale 1ns/1ps
module tb_rxaf_filter;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_hi = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        lkup_vld = 1'b0;
   logic [47:0] lkup_addr = '0;
   logic        hit_vld, hit;
   logic [3:0]  hit_idx;

   int vectors = 0, fails = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_lo [N];
   logic [15:0] m_hi [N];
   bit          m_av [N], m_pend [N];
   logic [31:0] m_stg;
   logic [3:0]  m_stg_idx;
   bit          m_stg_v;

   always #2.5 clk = ~clk;

   rxaf_filter dut (.*);

   function automatic logic [47:0] net(input logic [31:0] lo, input logic [15:0] hi);
      return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
   endfunction

   function automatic logic [5:0] expect_lookup(input logic [47:0] a);
      for (int i = 0; i < N; i++) begin
         if (m_av[i] && !m_pend[i] && {m_lo[i], m_hi[i]} != '0 &&
             net(m_lo[i], m_hi[i]) == a)
            return {1'b1, 1'b1, 4'(i)};
      end
      return 6'b10_0000;
   endfunction

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual vld/hit/idx=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] idx, input bit hi, input logic [31:0] d);
      logic [31:0] nlo;
      cfg_we = 1'b1; cfg_hi = hi; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!hi) begin
         m_stg = d; m_stg_idx = idx; m_stg_v = 1; m_pend[idx] = 1;
      end else begin
         nlo = (m_stg_v && m_stg_idx == idx) ? m_stg : m_lo[idx];
         if (!(idx == 0 && d[31] && nlo[0])) begin
            m_lo[idx] = nlo; m_hi[idx] = d[15:0]; m_av[idx] = d[31];
         end
         m_pend[idx] = 0; m_stg_v = 0;
      end
   endtask

   task automatic look(input string req, input logic [47:0] a);
      logic [5:0] e;
      e = expect_lookup(a);
      lkup_vld = 1'b1; lkup_addr = a;
      @(negedge clk);
      lkup_vld = 1'b0;
      check(req, {hit_vld, hit, hit_idx}, e);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < N; i++) begin
         m_lo[i] = '0; m_hi[i] = '0; m_av[i] = 0; m_pend[i] = 0;
      end
      m_stg = '0; m_stg_idx = '0; m_stg_v = 0;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {hit_vld, hit, hit_idx}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle no qualifier", {hit_vld, hit, hit_idx}, 6'b0);
      look("R1 empty table miss", 48'h0211_2233_4455);
      look("R5 zero address miss after reset", 48'h0);

      // R2 R3: entry 0 = 02:11:22:33:44:55
      wr(0, 0, 32'h3322_1102);
      wr(0, 1, 32'h8000_5544);
      look("R2 byte order hit", 48'h0211_2233_4455);
      look("R2 swapped order miss", 48'h5544_3322_1102);
      // R3 ignored bits 30:16
      wr(0, 1, 32'hFFFF_5544);
      look("R3 upper bits ignored", 48'h0211_2233_4455);

      // R9: duplicates in 9 and 5
      wr(9, 0, 32'hDDCC_BBAA); wr(9, 1, 32'h8000_FFEE);
      wr(5, 0, 32'hDDCC_BBAA); wr(5, 1, 32'h8000_FFEE);
      look("R9 lowest index wins", 48'hAABB_CCDD_EEFF);

      // R6: lone low write suppresses entry 5
      wr(5, 0, 32'h0403_0200);
      look("R6 pending entry suppressed", 48'hAABB_CCDD_EEFF);
      wr(5, 1, 32'h8000_0605);
      look("R6 committed new address", 48'h0002_0304_0506);
      look("R6 old address now only in 9", 48'hAABB_CCDD_EEFF);
      // R6 stale staging: low to 7, low to 8, high to 7 keeps old low of 7
      wr(7, 0, 32'h1111_1110); wr(7, 1, 32'h8000_1111);
      wr(7, 0, 32'h2222_2220); wr(8, 0, 32'h3333_3330);
      wr(7, 1, 32'h8000_4444);
      look("R6 foreign staging not committed", 48'h1011_1111_4444);

      // R4: clear valid on 9
      wr(9, 1, 32'h0000_FFEE);
      look("R4 invalid entry misses", 48'hAABB_CCDD_EEFF);

      // R7: multicast replacement of entry 0 rejected
      wr(0, 0, 32'h0000_0001); wr(0, 1, 32'h8000_0000);
      look("R7 old primary kept", 48'h0211_2233_4455);
      look("R7 group address refused", 48'h0100_0000_0000);

      // R5: zero address with valid flag
      wr(3, 0, 32'h0); wr(3, 1, 32'h8000_0000);
      look("R5 zero address never hits", 48'h0);

      // random mix
      for (int it = 0; it < 600; it++) begin
         logic [3:0]  ri;
         logic [31:0] d;
         int          k;
         ri = 4'($urandom_range(0, N - 1));
         k  = $urandom_range(0, 9);
         d  = $urandom;
         if ($urandom_range(0, 3) == 0) d[0] = 1'b1;
         if (k < 8) begin
            wr(ri, 0, d);
            wr(ri, 1, {($urandom_range(0, 3) != 0), 31'($urandom)});
         end else if (k == 8) begin
            wr(ri, 0, d);
         end else begin
            wr(ri, 1, {($urandom_range(0, 3) != 0), 31'($urandom)});
         end
         for (int j = 0; j < 2; j++) begin
            logic [3:0] li;
            li = 4'($urandom_range(0, N - 1));
            if ($urandom_range(0, 9) < 8)
               look("R9 random lookup", net(m_lo[li], m_hi[li]));
            else
               look("R8 random lookup", {16'($urandom), 32'($urandom)});
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule